// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the instruction-boundary controller of a small 8-bit accumulator processor. Each time an opcode is fetched it chooses between a reset, a non-maskable interrupt, a maskable interrupt, or the fetched opcode itself. When an interrupt or a software break wins, it pushes the return address and the status byte on the hardware stack over a byte-wide memory bus, sets the interrupt-disable flag and loads the program counter from a fixed vector near the top of memory. A reset takes three stack cycles that move the stack pointer but never write. The block also owns the status-byte formatting for the push-status and pull-status opcodes, the two interrupt-mask opcodes, the set-overflow input and the register values at power-up.

Opcodes that the block does not handle itself are handed to the execution unit. The unit gets a one-cycle valid pulse and the opcode byte, and the next fetch follows at once. The bus shows an address, write data, a read/write level and a sync output that marks opcode fetches.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, A=0x00, X=0x80, Y=0x00, status=0x20 and the stack pointer is 0xFF. After release, the block runs the reset entry of R5 and R8.
- R2: Requests are judged only in an opcode-fetch cycle, in this order: reset request (`rst_req_n` low), a pending non-maskable request, then the maskable request. `sync` is high in exactly the cycles that fetch an opcode.
- R3: The maskable request (`irq_n` low) is level-sensitive. It is not taken while the interrupt-disable flag (status bit 2) is 1.
- R4: A falling edge on `nmi_n` is latched as pending. It is taken once, at the first fetch where no reset request is present, and then cleared.
- R5: A reset entry performs three read cycles at 0x0100+S. Each one decrements S, and nothing is written.
- R6: An interrupt or break entry writes the PC high byte, then the PC low byte, then the status byte, each at 0x0100+S followed by a decrement of S. A hardware entry pushes the address of the abandoned opcode. A break (opcode 0x00) reads one padding byte and pushes the opcode address plus 2.
- R7: The pushed status has bit 5 set. Bit 4 is 1 for a break and 0 for a hardware interrupt.
- R8: Every entry sets status bit 2 and loads the PC low byte from the vector, then the high byte from the vector plus 1. The vectors are 0xFFFA for the non-maskable request, 0xFFFC for reset, and 0xFFFE for the maskable request and break.
- R9: Opcode 0x08 writes the status byte with bit 4 set at 0x0100+S. Opcode 0x28 does one read at 0x0100+S, increments S, then reads 0x0100+S and loads the status with bit 5 forced to 1 and bit 4 forced to 0.
- R10: Opcode 0x58 clears status bit 2. Opcode 0x78 sets it.
- R11: `set_ovf_n` low in any cycle sets status bit 6 at that clock edge. This also holds while `ready` is low and in the cycle that loads a pulled status.
- R12: With `ready` low in a fetch cycle, no fetch takes place: `sync` is low, the address holds and no state changes apart from R11 and R4.
- R13: Any other fetched opcode raises `op_valid` for one cycle with `op_code` equal to the byte, and the next fetch reads PC+1.
- R14: `rw` is 1 in every read cycle. It is 0 only in stack writes, whose address high byte is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous |
| ready | input | 1 | Allows an opcode fetch at an instruction boundary |
| rst_req_n | input | 1 | Reset request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| irq_n | input | 1 | Maskable request, level, active low |
| set_ovf_n | input | 1 | Sets the overflow flag while low |
| din | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| dout | output | 8 | Write data |
| rw | output | 1 | 1 = read, 0 = write |
| sync | output | 1 | High in opcode-fetch cycles |
| op_valid | output | 1 | One-cycle pulse for a dispatched opcode |
| op_code | output | 8 | Dispatched opcode |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | X index |
| reg_y | output | 8 | Y index |
| reg_s | output | 8 | Stack pointer |
| reg_p | output | 8 | Status register |

## Verification
Two cases can fall in the same cycle. The first is the set-overflow input and the load of a pulled status byte, which both write the status register on one edge. The bench holds `set_ovf_n` low in exactly the cycle that reads the pulled byte. It judges the result by bit 6 being 1 while the other bits follow the pulled byte with bits 5 and 4 forced. The second case is a reset request and a latched non-maskable edge at the same fetch. The bench expects the reset stack cycles first and the non-maskable entry at the first fetch after the reset vector.

// File: rtl/ies_pkg.sv
package ies_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_PAD,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_SPIN,
        ST_VEC_L,
        ST_VEC_H,
        ST_PULL_SPIN,
        ST_PULL_RD
    } seq_state_e;

    typedef enum logic [2:0] {
        EK_RESET,
        EK_NMI,
        EK_IRQ,
        EK_BRK,
        EK_PHP
    } entry_kind_e;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_RESET,
        PICK_NMI,
        PICK_IRQ
    } pick_e;

    // status flag positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_I = 2;
    localparam int FL_D = 3;
    localparam int FL_B = 4;
    localparam int FL_R = 5;
    localparam int FL_V = 6;
    localparam int FL_N = 7;

    // opcodes handled inside the sequencer
    localparam logic [7:0] OP_BREAK = 8'h00;
    localparam logic [7:0] OP_PUSHP = 8'h08;
    localparam logic [7:0] OP_PULLP = 8'h28;
    localparam logic [7:0] OP_CLRI  = 8'h58;
    localparam logic [7:0] OP_SETI  = 8'h78;

endpackage

// File: rtl/ies_nmi_latch.sv
module ies_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    logic prev_d, prev_q;
    logic pend_d, pend_q;

    always_comb begin
        prev_d = nmi_n;
        pend_d = (pend_q & ~take) | (prev_q & ~nmi_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter
    import ies_pkg::*;
(
    input  logic  reset_req,
    input  logic  nmi_pend,
    input  logic  irq_req,
    input  logic  irq_masked,
    output pick_e pick
);
    always_comb begin
        if (reset_req)
            pick = PICK_RESET;
        else if (nmi_pend)
            pick = PICK_NMI;
        else if (irq_req && !irq_masked)
            pick = PICK_IRQ;
        else
            pick = PICK_NONE;
    end
endmodule

// File: rtl/ies_status_fmt.sv
module ies_status_fmt
    import ies_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] p_now,
    input  logic              brk_bit,
    input  logic [DATA_W-1:0] pulled,
    output logic [DATA_W-1:0] push_byte,
    output logic [DATA_W-1:0] pull_byte
);
    always_comb begin
        push_byte        = p_now;
        push_byte[FL_R]  = 1'b1;
        push_byte[FL_B]  = brk_bit;
        pull_byte        = pulled;
        pull_byte[FL_R]  = 1'b1;
        pull_byte[FL_B]  = 1'b0;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import ies_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          RESET_SPINS = 3,
    parameter logic [7:0]  STACK_PAGE  = 8'h01,
    parameter logic [7:0]  VEC_PAGE    = 8'hFF,
    parameter logic [7:0]  NMI_LO      = 8'hFA,
    parameter logic [7:0]  RST_LO      = 8'hFC,
    parameter logic [7:0]  IRQ_LO      = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              rst_req_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              set_ovf_n,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              rw,
    output logic              sync,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_code,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_x,
    output logic [DATA_W-1:0] reg_y,
    output logic [DATA_W-1:0] reg_s,
    output logic [DATA_W-1:0] reg_p
);
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int SPIN_W = $clog2(RESET_SPINS + 1);
    localparam logic [SPIN_W-1:0] SPIN_LAST = SPIN_W'(RESET_SPINS - 1);
    localparam logic [DATA_W-1:0] P_INIT = DATA_W'(1) << FL_R;
    localparam logic [DATA_W-1:0] X_INIT = DATA_W'(1) << (DATA_W - 1);

    typedef struct packed {
        seq_state_e        state;
        entry_kind_e       kind;
        logic [SPIN_W-1:0] spin;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] p;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] vlo;
        logic              opv;
        logic [DATA_W-1:0] opc;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              nmi_pend;
    logic              take_nmi;
    pick_e             pick;
    logic [DATA_W-1:0] push_byte;
    logic [DATA_W-1:0] pull_byte;
    logic              brk_bit;
    logic [DATA_W-1:0] vec_lo;
    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] addr_c;
    logic [DATA_W-1:0] dout_c;
    logic              rw_c;
    logic              sync_c;

    ies_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .take    (take_nmi),
        .pending (nmi_pend)
    );

    ies_arbiter u_arb (
        .reset_req  (~rst_req_n),
        .nmi_pend   (nmi_pend),
        .irq_req    (~irq_n),
        .irq_masked (r_q.p[FL_I]),
        .pick       (pick)
    );

    assign brk_bit = (r_q.kind == EK_BRK) || (r_q.kind == EK_PHP);

    ies_status_fmt #(.DATA_W(DATA_W)) u_fmt (
        .p_now     (r_q.p),
        .brk_bit   (brk_bit),
        .pulled    (din),
        .push_byte (push_byte),
        .pull_byte (pull_byte)
    );

    always_comb begin
        case (r_q.kind)
            EK_RESET: vec_lo = RST_LO;
            EK_NMI:   vec_lo = NMI_LO;
            default:  vec_lo = IRQ_LO;
        endcase
        stack_addr = {HI_W'(STACK_PAGE), r_q.sp};
    end

    always_comb begin
        r_d      = r_q;
        r_d.opv  = 1'b0;
        addr_c   = r_q.pc;
        dout_c   = '0;
        rw_c     = 1'b1;
        sync_c   = 1'b0;
        take_nmi = 1'b0;

        case (r_q.state)
            ST_FETCH: begin
                if (ready) begin
                    sync_c = 1'b1;
                    r_d.pc = r_q.pc + ADDR_W'(1);
                    case (pick)
                        PICK_RESET: begin
                            r_d.state = ST_SPIN;
                            r_d.kind  = EK_RESET;
                            r_d.spin  = '0;
                            r_d.pc    = r_q.pc;
                        end
                        PICK_NMI: begin
                            take_nmi  = 1'b1;
                            r_d.state = ST_PUSH_H;
                            r_d.kind  = EK_NMI;
                            r_d.pc    = r_q.pc;
                        end
                        PICK_IRQ: begin
                            r_d.state = ST_PUSH_H;
                            r_d.kind  = EK_IRQ;
                            r_d.pc    = r_q.pc;
                        end
                        default: begin
                            case (din)
                                OP_BREAK: begin
                                    r_d.state = ST_PAD;
                                    r_d.kind  = EK_BRK;
                                end
                                OP_PUSHP: begin
                                    r_d.state = ST_PUSH_P;
                                    r_d.kind  = EK_PHP;
                                end
                                OP_PULLP: r_d.state = ST_PULL_SPIN;
                                OP_CLRI:  r_d.p[FL_I] = 1'b0;
                                OP_SETI:  r_d.p[FL_I] = 1'b1;
                                default: begin
                                    r_d.opv = 1'b1;
                                    r_d.opc = din;
                                end
                            endcase
                        end
                    endcase
                end
            end
            ST_PAD: begin
                r_d.pc    = r_q.pc + ADDR_W'(1);
                r_d.state = ST_PUSH_H;
            end
            ST_PUSH_H: begin
                addr_c    = stack_addr;
                rw_c      = 1'b0;
                dout_c    = r_q.pc[ADDR_W-1 -: DATA_W];
                r_d.sp    = r_q.sp - DATA_W'(1);
                r_d.state = ST_PUSH_L;
            end
            ST_PUSH_L: begin
                addr_c    = stack_addr;
                rw_c      = 1'b0;
                dout_c    = r_q.pc[DATA_W-1:0];
                r_d.sp    = r_q.sp - DATA_W'(1);
                r_d.state = ST_PUSH_P;
            end
            ST_PUSH_P: begin
                addr_c = stack_addr;
                rw_c   = 1'b0;
                dout_c = push_byte;
                r_d.sp = r_q.sp - DATA_W'(1);
                if (r_q.kind == EK_PHP) begin
                    r_d.state = ST_FETCH;
                end else begin
                    r_d.state   = ST_VEC_L;
                    r_d.p[FL_I] = 1'b1;
                end
            end
            ST_SPIN: begin
                addr_c   = stack_addr;
                r_d.sp   = r_q.sp - DATA_W'(1);
                r_d.spin = r_q.spin + SPIN_W'(1);
                if (r_q.spin == SPIN_LAST) begin
                    r_d.state   = ST_VEC_L;
                    r_d.p[FL_I] = 1'b1;
                end
            end
            ST_VEC_L: begin
                addr_c    = {HI_W'(VEC_PAGE), vec_lo};
                r_d.vlo   = din;
                r_d.state = ST_VEC_H;
            end
            ST_VEC_H: begin
                addr_c    = {HI_W'(VEC_PAGE), vec_lo + DATA_W'(1)};
                r_d.pc    = {din, r_q.vlo};
                r_d.state = ST_FETCH;
            end
            ST_PULL_SPIN: begin
                addr_c    = stack_addr;
                r_d.sp    = r_q.sp + DATA_W'(1);
                r_d.state = ST_PULL_RD;
            end
            ST_PULL_RD: begin
                addr_c    = stack_addr;
                r_d.p     = pull_byte;
                r_d.state = ST_FETCH;
            end
            default: r_d.state = ST_FETCH;
        endcase

        if (!set_ovf_n)
            r_d.p[FL_V] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_SPIN;
            r_q.kind  <= EK_RESET;
            r_q.spin  <= '0;
            r_q.pc    <= '0;
            r_q.sp    <= '1;
            r_q.p     <= P_INIT;
            r_q.a     <= '0;
            r_q.x     <= X_INIT;
            r_q.y     <= '0;
            r_q.vlo   <= '0;
            r_q.opv   <= 1'b0;
            r_q.opc   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr     = addr_c;
    assign dout     = dout_c;
    assign rw       = rw_c;
    assign sync     = sync_c;
    assign op_valid = r_q.opv;
    assign op_code  = r_q.opc;
    assign reg_a    = r_q.a;
    assign reg_x    = r_q.x;
    assign reg_y    = r_q.y;
    assign reg_s    = r_q.sp;
    assign reg_p    = r_q.p;
endmodule

// File: rtl/ies_chk.sv
module ies_chk #(
    parameter int         ADDR_W     = 16,
    parameter int         DATA_W     = 8,
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req_n,
    input logic              set_ovf_n,
    input logic              rw,
    input logic              sync,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] reg_s,
    input logic [DATA_W-1:0] reg_p
);
    localparam int HI_W = ADDR_W - DATA_W;

    // R14
    stack_write_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> addr[ADDR_W-1:DATA_W] == HI_W'(STACK_PAGE));

    // R6
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |=> reg_s == $past(reg_s) - DATA_W'(1));

    // R2
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> rw);

    // R11
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_ovf_n |=> reg_p[6]);

    // R5
    reset_spin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !rst_req_n) |=> (rw && !sync && addr[ADDR_W-1:DATA_W] == HI_W'(STACK_PAGE)));

    // R9
    reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_p[5]);
endmodule

bind irq_entry_seq ies_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req_n (rst_req_n),
    .set_ovf_n (set_ovf_n),
    .rw        (rw),
    .sync      (sync),
    .addr      (addr),
    .reg_s     (reg_s),
    .reg_p     (reg_p)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n, ready, rst_req_n, nmi_n, irq_n, set_ovf_n;
    logic [7:0]  din;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        rw, sync, op_valid;
    logic [7:0]  op_code, reg_a, reg_x, reg_y, reg_s, reg_p;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] prog  [256];
    logic [7:0] stack [256];
    logic       patch_en  = 1'b0;
    logic [7:0] patch_val = 8'h00;

    always #10 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .ready(ready), .rst_req_n(rst_req_n),
        .nmi_n(nmi_n), .irq_n(irq_n), .set_ovf_n(set_ovf_n), .din(din),
        .addr(addr), .dout(dout), .rw(rw), .sync(sync), .op_valid(op_valid),
        .op_code(op_code), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .reg_s(reg_s), .reg_p(reg_p)
    );

    // memory model: vectors at the top page, stack page, program wraps by low byte
    always_comb begin
        if (addr[15:8] == 8'hFF) begin
            case (addr[7:0])
                8'hFA:   din = 8'h40;
                8'hFB:   din = 8'h02;
                8'hFC:   din = 8'h00;
                8'hFD:   din = 8'h02;
                8'hFE:   din = 8'h80;
                8'hFF:   din = 8'h02;
                default: din = 8'hEA;
            endcase
        end else if (addr[15:8] == 8'h01) begin
            din = (patch_en && addr[7:0] == 8'hFC) ? patch_val : stack[addr[7:0]];
        end else begin
            din = prog[addr[7:0]];
        end
    end

    always @(posedge clk) begin
        if (rst_n && !rw)
            stack[addr[7:0]] <= dout;
    end

    function automatic logic [7:0] push_status(input logic [7:0] p, input logic brk);
        return (p | 8'h20) & 8'hEF | (brk ? 8'h10 : 8'h00);
    endfunction

    function automatic logic [7:0] pull_status(input logic [7:0] v);
        return (v | 8'h20) & 8'hEF;
    endfunction

    function automatic bit is_special(input logic [7:0] b);
        return b == 8'h00 || b == 8'h08 || b == 8'h28 || b == 8'h58 || b == 8'h78;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic see(input logic [15:0] ea, input logic erw, input logic esync, input string tag);
        @(negedge clk);
        chk({tag, " addr"}, addr, ea);
        chk({tag, " rw"}, rw, erw);
        chk({tag, " sync"}, sync, esync);
    endtask

    task automatic seew(input logic [15:0] ea, input logic [7:0] ed, input string tag);
        see(ea, 1'b0, 1'b0, tag);
        chk({tag, " dout"}, dout, ed);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_pc;
        logic [7:0]  b;
        b = 8'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) begin
            prog[i]  = 8'hEA;
            stack[i] = 8'h00;
        end
        prog[8'h00] = 8'h58;
        prog[8'h01] = 8'hEA;
        prog[8'h02] = 8'h08;
        prog[8'h03] = 8'h28;
        prog[8'h04] = 8'h58;
        prog[8'h80] = 8'h00;
        prog[8'h81] = 8'hFF;
        for (int i = 8'h41; i < 8'h70; i++) begin
            b = 8'($urandom);
            while (is_special(b)) b = 8'($urandom);
            prog[i] = b;
        end

        rst_n = 1'b0; ready = 1'b1; rst_req_n = 1'b1;
        nmi_n = 1'b1; irq_n = 1'b1; set_ovf_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 power-up values
        chk("R1 A", reg_a, 8'h00);
        chk("R1 X", reg_x, 8'h80);
        chk("R1 Y", reg_y, 8'h00);
        chk("R1 P", reg_p, 8'h20);
        chk("R1 S", reg_s, 8'hFF);
        rst_n = 1'b1;
        chk("R5 spin1 addr", addr, 16'h01FF);
        chk("R5 spin1 rw", rw, 1'b1);
        see(16'h01FE, 1'b1, 1'b0, "R5 spin2");
        see(16'h01FD, 1'b1, 1'b0, "R5 spin3");
        see(16'hFFFC, 1'b1, 1'b0, "R8 reset vec lo");
        see(16'hFFFD, 1'b1, 1'b0, "R8 reset vec hi");
        see(16'h0200, 1'b1, 1'b1, "R8 reset target");
        chk("R5 S after reset", reg_s, 8'hFC);
        chk("R8 I after reset", reg_p, 8'h24);

        // R12 stall with ready low, R11 overflow while stalled
        ready = 1'b0;
        see(16'h0200, 1'b1, 1'b0, "R12 stall");
        chk("R12 P held", reg_p, 8'h24);
        set_ovf_n = 1'b0;
        see(16'h0200, 1'b1, 1'b0, "R12 stall2");
        chk("R11 V while stalled", reg_p, 8'h64);
        chk("R12 no dispatch", op_valid, 1'b0);
        set_ovf_n = 1'b1; ready = 1'b1;

        see(16'h0201, 1'b1, 1'b1, "R10 after clear-I");
        chk("R10 I cleared", reg_p, 8'h60);
        chk("R13 internal op not dispatched", op_valid, 1'b0);
        see(16'h0202, 1'b1, 1'b1, "R13 next fetch");
        chk("R13 op_valid", op_valid, 1'b1);
        chk("R13 op_code", op_code, 8'hEA);
        seew(16'h01FC, push_status(8'h60, 1'b1), "R9 push status");
        see(16'h0203, 1'b1, 1'b1, "R9 after push");
        chk("R9 S after push", reg_s, 8'hFB);
        patch_en = 1'b1; patch_val = 8'h9F;
        see(16'h01FB, 1'b1, 1'b0, "R9 pull spin");
        see(16'h01FC, 1'b1, 1'b0, "R9 pull read");
        chk("R9 S after pull", reg_s, 8'hFC);
        set_ovf_n = 1'b0;
        see(16'h0204, 1'b1, 1'b1, "R9 after pull");
        chk("R11 V wins over pulled byte", reg_p, pull_status(8'h9F) | 8'h40);
        set_ovf_n = 1'b1; patch_en = 1'b0;

        irq_n = 1'b0;
        see(16'h0205, 1'b1, 1'b1, "R3 masked irq ignored");
        chk("R10 clear-I after masked irq", reg_p, 8'hEB);
        seew(16'h01FC, 8'h02, "R6 irq PCH");
        seew(16'h01FB, 8'h05, "R6 irq PCL");
        seew(16'h01FA, push_status(8'hEB, 1'b0), "R7 irq status");
        irq_n = 1'b1;
        see(16'hFFFE, 1'b1, 1'b0, "R8 irq vec lo");
        see(16'hFFFF, 1'b1, 1'b0, "R8 irq vec hi");
        see(16'h0280, 1'b1, 1'b1, "R8 irq target");
        chk("R8 I set by irq", reg_p, 8'hEF);
        chk("R6 S after irq", reg_s, 8'hF9);

        see(16'h0281, 1'b1, 1'b0, "R6 break pad");
        nmi_n = 1'b0;
        seew(16'h01F9, 8'h02, "R6 break PCH");
        seew(16'h01F8, 8'h82, "R6 break PCL");
        seew(16'h01F7, push_status(8'hEF, 1'b1), "R7 break status");
        see(16'hFFFE, 1'b1, 1'b0, "R8 break vec lo");
        see(16'hFFFF, 1'b1, 1'b0, "R8 break vec hi");
        rst_req_n = 1'b0;
        see(16'h0280, 1'b1, 1'b1, "R2 fetch with reset and nmi");
        see(16'h01F6, 1'b1, 1'b0, "R2 reset wins");
        rst_req_n = 1'b1; nmi_n = 1'b1;
        see(16'h01F5, 1'b1, 1'b0, "R5 spin2 again");
        see(16'h01F4, 1'b1, 1'b0, "R5 spin3 again");
        see(16'hFFFC, 1'b1, 1'b0, "R8 reset vec lo again");
        see(16'hFFFD, 1'b1, 1'b0, "R8 reset vec hi again");
        see(16'h0200, 1'b1, 1'b1, "R4 fetch with pending nmi");
        chk("R5 S after second reset", reg_s, 8'hF3);
        seew(16'h01F3, 8'h02, "R4 nmi PCH");
        seew(16'h01F2, 8'h00, "R4 nmi PCL");
        seew(16'h01F1, push_status(8'hEF, 1'b0), "R7 nmi status");
        see(16'hFFFA, 1'b1, 1'b0, "R8 nmi vec lo");
        see(16'hFFFB, 1'b1, 1'b0, "R8 nmi vec hi");
        see(16'h0240, 1'b1, 1'b1, "R8 nmi target");
        chk("R6 S after nmi", reg_s, 8'hF0);
        see(16'h0241, 1'b1, 1'b1, "R4 nmi taken once");

        // random dispatch stream, masked irq noise, random stalls
        exp_pc = 16'h0241;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R13 rand op_valid", op_valid, 1'b1);
            chk("R13 rand op_code", op_code, prog[exp_pc[7:0]]);
            exp_pc = exp_pc + 16'd1;
            chk("R13 rand next addr", addr, exp_pc);
            chk("R3 rand masked irq no entry", sync, 1'b1);
            irq_n = 1'($urandom);
            if ($urandom % 3 == 0) begin
                ready = 1'b0;
                #1;
                chk("R12 rand sync low", sync, 1'b0);
                @(negedge clk);
                chk("R12 rand no dispatch", op_valid, 1'b0);
                chk("R12 rand addr held", addr, exp_pc);
                ready = 1'b1;
                #1;
                chk("R2 rand sync back", sync, 1'b1);
            end
        end
        irq_n = 1'b1;
        chk("R14 final read level", rw, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule